// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable slave that behaves like a small three-wire serial EEPROM of 128 bytes. A host selects it with a chip-select input, shifts command frames in on a serial data input, one bit per rising edge of a serial clock, and reads answers on a serial data output. The serial clock and data are sampled with the system clock. A rising serial-clock edge is the system-clock cycle in which the serial clock is high after being low in the previous cycle.

A frame consists of a start bit, a two-bit opcode and a seven-bit address, and carries eight data bits for the storing commands. The block supports single-byte read, write and erase, whole-array erase and write, and a write-protect latch that is set and cleared by command. A storing command takes effect when chip select drops after a complete frame. The block then counts a programming time in system-clock cycles. While that time runs, the data output reports busy whenever chip select is high, and serial input is ignored.

Top module: `serial_nvm_slave`

## Requirements
- R1: After reset every byte reads 0xFF, writes are locked, and the data output is 1 while chip select is high and no read is in progress.
- R2: Serial-clock rises that carry a 0 before the start bit are skipped. The frame is a start bit of 1, then the opcode (two bits, most significant first), then the address (seven bits, most significant first). Opcode 2'b10 is a read.
- R3: After the last address bit of a read, the output shows a 0. Each following rise then presents one of the eight stored bits, most significant first. Any rise after the eighth bit returns the output to 1.
- R4: Opcode 2'b01, followed by eight data bits sent most significant first, stores the byte at the address. The store happens when chip select falls after all eight data bits.
- R5: Opcode 2'b11 sets the addressed byte to 0xFF when chip select falls after the address.
- R6: Opcode 2'b00 decodes the two top address bits. 2'b11 unlocks writing and 2'b00 locks it, each taking effect at the last address bit. While writing is locked, every storing command leaves the memory unchanged and starts no busy period.
- R7: With opcode 2'b00, address top bits 2'b10 set every byte to 0xFF. Address top bits 2'b01, followed by eight data bits, write that byte into every location.
- R8: After an accepted storing command, the output reads 0 while chip select is high, for PROG_CYCLES system-clock cycles counted from the cycle of the chip-select fall. After that the output reads 1.
- R9: A serial-clock rise is ignored while the output reports busy. This includes a rise seen in the last busy cycle. A full frame clocked in during busy changes nothing.
- R10: If chip select falls before a frame is complete, the command is aborted. Memory is unchanged and no busy period starts.
- R11: While chip select is low, the data output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock, sampled by clk |
| sdi_i | input | 1 | Serial data into the device |
| sdo_o | output | 1 | Serial data / ready-busy out of the device |

## Verification
The end of a programming period and the arrival of the next serial-clock rise can fall in the same cycle. In that cycle the timer clears, and the frame decoder has to decide whether the rise counts. The bench holds chip select high through a busy period. It raises the serial clock with a 1 on the input in exactly the last cycle that the output still reports busy, then sends a read frame straight after. The read must return the written byte behind a proper dummy 0. If the early rise had been taken as a start bit, the frame would decode differently. A behavioural reference model compares the output on every clock through this window.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_HDR,
        FS_DATA,
        FS_READ,
        FS_ARMED,
        FS_DONE
    } frame_st_e;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } opcode_e;

    typedef enum logic [1:0] {
        EXT_LOCK   = 2'b00,
        EXT_FILL   = 2'b01,
        EXT_BLANK  = 2'b10,
        EXT_UNLOCK = 2'b11
    } ext_e;

    typedef enum logic [2:0] {
        PK_NONE,
        PK_WRITE,
        PK_ERASE,
        PK_BLANK_ALL,
        PK_FILL_ALL
    } prog_kind_e;

endpackage

// File: rtl/nvm_frame_rx.sv
module nvm_frame_rx
    import nvm_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              ready_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              dout_o,
    output logic              commit_o,
    output prog_kind_e        kind_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              lock_clr_o,
    output logic              lock_set_o
);

    localparam int HDR_W   = ADDR_W + 2;
    localparam int CNT_MAX = (HDR_W > DATA_W) ? HDR_W : DATA_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        frame_st_e         st;
        logic              sclk_prev;
        logic [HDR_W-2:0]  hdr;
        logic [DATA_W-1:0] wdat;
        logic [DATA_W-1:0] rsh;
        logic [CNT_W-1:0]  cnt;
        logic              dout;
        prog_kind_e        kind;
    } rx_state_t;

    localparam rx_state_t RX_RST = '{
        st:        FS_IDLE,
        sclk_prev: 1'b0,
        hdr:       '0,
        wdat:      '0,
        rsh:       '0,
        cnt:       '0,
        dout:      1'b1,
        kind:      PK_NONE
    };

    rx_state_t        s_d, s_q;
    logic             rise;
    logic [HDR_W-1:0] hdr_next;

    always_comb begin
        s_d         = s_q;
        s_d.sclk_prev = sclk_i;
        rise        = sclk_i & ~s_q.sclk_prev;
        hdr_next    = {s_q.hdr, sdi_i};
        rd_addr_o   = hdr_next[ADDR_W-1:0];
        commit_o    = 1'b0;
        lock_clr_o  = 1'b0;
        lock_set_o  = 1'b0;

        if (!sel_i) begin
            commit_o = (s_q.st == FS_ARMED);
            s_d.st   = FS_IDLE;
            s_d.cnt  = '0;
            s_d.dout = 1'b1;
        end else if (rise && ready_i) begin
            case (s_q.st)
                FS_IDLE: begin
                    if (sdi_i) begin
                        s_d.st  = FS_HDR;
                        s_d.cnt = '0;
                    end
                end
                FS_HDR: begin
                    s_d.hdr = hdr_next[HDR_W-2:0];
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                    if (s_q.cnt == CNT_W'(HDR_W - 1)) begin
                        s_d.cnt = '0;
                        case (opcode_e'(hdr_next[HDR_W-1 -: 2]))
                            OP_READ: begin
                                s_d.st   = FS_READ;
                                s_d.rsh  = rd_data_i;
                                s_d.dout = 1'b0;
                            end
                            OP_WRITE: begin
                                s_d.kind = PK_WRITE;
                                s_d.st   = FS_DATA;
                            end
                            OP_ERASE: begin
                                s_d.kind = PK_ERASE;
                                s_d.st   = FS_ARMED;
                            end
                            default: begin
                                case (ext_e'(hdr_next[ADDR_W-1 -: 2]))
                                    EXT_UNLOCK: begin
                                        lock_clr_o = 1'b1;
                                        s_d.st     = FS_DONE;
                                    end
                                    EXT_LOCK: begin
                                        lock_set_o = 1'b1;
                                        s_d.st     = FS_DONE;
                                    end
                                    EXT_BLANK: begin
                                        s_d.kind = PK_BLANK_ALL;
                                        s_d.st   = FS_ARMED;
                                    end
                                    default: begin
                                        s_d.kind = PK_FILL_ALL;
                                        s_d.st   = FS_DATA;
                                    end
                                endcase
                            end
                        endcase
                    end
                end
                FS_DATA: begin
                    s_d.wdat = {s_q.wdat[DATA_W-2:0], sdi_i};
                    s_d.cnt  = s_q.cnt + CNT_W'(1);
                    if (s_q.cnt == CNT_W'(DATA_W - 1)) begin
                        s_d.st = FS_ARMED;
                    end
                end
                FS_READ: begin
                    if (s_q.cnt == CNT_W'(DATA_W)) begin
                        s_d.st   = FS_DONE;
                        s_d.dout = 1'b1;
                    end else begin
                        s_d.dout = s_q.rsh[DATA_W-1];
                        s_d.rsh  = {s_q.rsh[DATA_W-2:0], 1'b0};
                        s_d.cnt  = s_q.cnt + CNT_W'(1);
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= RX_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout_o = s_q.dout;
    assign kind_o = s_q.kind;
    assign addr_o = s_q.hdr[ADDR_W-1:0];
    assign data_o = s_q.wdat;

endmodule

// File: rtl/nvm_store.sv
module nvm_store
    import nvm_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  prog_kind_e        kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              lock_clr_i,
    input  logic              lock_set_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              wen_o,
    output logic              accept_o
);

    localparam int                DEPTH = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] BLANK = '1;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              wen_d, wen_q;

    always_comb begin
        mem_d    = mem_q;
        wen_d    = wen_q;
        accept_o = commit_i && wen_q && (kind_i != PK_NONE);

        if (lock_clr_i) begin
            wen_d = 1'b1;
        end else if (lock_set_i) begin
            wen_d = 1'b0;
        end

        if (accept_o) begin
            case (kind_i)
                PK_WRITE: mem_d[addr_i] = data_i;
                PK_ERASE: mem_d[addr_i] = BLANK;
                PK_BLANK_ALL: begin
                    for (int i = 0; i < DEPTH; i++) mem_d[i] = BLANK;
                end
                PK_FILL_ALL: begin
                    for (int i = 0; i < DEPTH; i++) mem_d[i] = data_i;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= BLANK;
            wen_q <= 1'b0;
        end else begin
            mem_q <= mem_d;
            wen_q <= wen_d;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];
    assign wen_o     = wen_q;

endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
    parameter int PROG_CYCLES = 1_200_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CW'(PROG_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/serial_nvm_slave.sv
module serial_nvm_slave
    import nvm_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 1_200_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic sdo_o
);

    logic              prog_busy;
    logic              prog_accept;
    logic              wen_en;
    logic              rx_dout;
    logic              rx_commit;
    prog_kind_e        rx_kind;
    logic [ADDR_W-1:0] rx_addr;
    logic [DATA_W-1:0] rx_data;
    logic              rx_lock_clr;
    logic              rx_lock_set;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    nvm_frame_rx #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel_i),
        .sclk_i     (sclk_i),
        .sdi_i      (sdi_i),
        .ready_i    (~prog_busy),
        .rd_data_i  (rd_data),
        .rd_addr_o  (rd_addr),
        .dout_o     (rx_dout),
        .commit_o   (rx_commit),
        .kind_o     (rx_kind),
        .addr_o     (rx_addr),
        .data_o     (rx_data),
        .lock_clr_o (rx_lock_clr),
        .lock_set_o (rx_lock_set)
    );

    nvm_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (rx_commit),
        .kind_i     (rx_kind),
        .addr_i     (rx_addr),
        .data_i     (rx_data),
        .lock_clr_i (rx_lock_clr),
        .lock_set_i (rx_lock_set),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .wen_o      (wen_en),
        .accept_o   (prog_accept)
    );

    nvm_prog_timer #(
        .PROG_CYCLES (PROG_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (prog_accept),
        .busy_o  (prog_busy)
    );

    always_comb begin
        if (!sel_i) begin
            sdo_o = 1'b1;
        end else if (prog_busy) begin
            sdo_o = 1'b0;
        end else begin
            sdo_o = rx_dout;
        end
    end

endmodule

// File: rtl/serial_nvm_slave_chk.sv
module serial_nvm_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_i,
    input logic sdo_o,
    input logic busy,
    input logic wen,
    input logic accept
);

    // R11: deselected output idles high
    p_idle_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |-> sdo_o);

    // R8: busy is reported low under chip select
    p_busy_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && busy) |-> !sdo_o);

    // R6: a programming period only starts when writes were unlocked
    p_locked_no_prog_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wen));

    // R10: programming only starts from a deselect edge
    p_prog_on_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(sel_i));

    // R9: nothing is accepted while a programming period runs
    p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !busy);

    // R9: the write latch holds still during programming
    p_lock_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(wen));

endmodule

bind serial_nvm_slave serial_nvm_slave_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_i  (sel_i),
    .sdo_o  (sdo_o),
    .busy   (prog_busy),
    .wen    (wen_en),
    .accept (prog_accept)
);

// File: tb/serial_nvm_slave_tb.sv
`timescale 1ns/100ps
module serial_nvm_slave_tb;

    localparam int TB_PROG = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo;

    int    n_run = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    serial_nvm_slave #(
        .ADDR_W      (7),
        .DATA_W      (8),
        .PROG_CYCLES (TB_PROG)
    ) u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel),
        .sclk_i (sclk),
        .sdi_i  (sdi),
        .sdo_o  (sdo)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit [7:0] m_mem [128];
    bit       m_wen;
    int       m_busy;
    bit       m_prev;
    int       m_q[$];
    bit       m_rd;
    int       m_idx;
    bit [7:0] m_rbyte;
    bit       m_out;

    function automatic int qv(int lo, int n);
        int v = 0;
        for (int i = 0; i < n; i++) v = (v << 1) | m_q[lo + i];
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) m_mem[i] = 8'hFF;
            m_wen = 0; m_busy = 0; m_prev = 0; m_q.delete();
            m_rd = 0; m_idx = 0; m_out = 1;
        end else begin
            bit rise;
            bit was_busy;
            rise = sclk && !m_prev;
            m_prev = sclk;
            was_busy = (m_busy > 0);
            if (m_busy > 0) m_busy--;
            if (!sel) begin
                if (m_q.size() >= 10) begin
                    int op, ad, sb, need;
                    bit prog;
                    op = qv(1, 2); ad = qv(3, 7); sb = ad >> 5;
                    need = (op == 1 || (op == 0 && sb == 1)) ? 18 : 10;
                    prog = (op != 2) && !(op == 0 && (sb == 3 || sb == 0));
                    if (prog && m_q.size() >= need && m_wen) begin
                        if (op == 1) m_mem[ad] = 8'(qv(10, 8));
                        else if (op == 3) m_mem[ad] = 8'hFF;
                        else if (sb == 2) for (int i = 0; i < 128; i++) m_mem[i] = 8'hFF;
                        else for (int i = 0; i < 128; i++) m_mem[i] = 8'(qv(10, 8));
                        m_busy = TB_PROG;
                    end
                end
                m_q.delete(); m_rd = 0; m_out = 1;
            end else if (rise && !was_busy) begin
                if (m_q.size() > 0 || sdi) begin
                    m_q.push_back(int'(sdi));
                    if (m_q.size() == 10) begin
                        int op, ad;
                        op = qv(1, 2); ad = qv(3, 7);
                        if (op == 2) begin
                            m_rd = 1; m_idx = 0; m_rbyte = m_mem[ad]; m_out = 0;
                        end else if (op == 0 && (ad >> 5) == 3) m_wen = 1;
                        else if (op == 0 && (ad >> 5) == 0) m_wen = 0;
                    end else if (m_q.size() > 10 && m_rd) begin
                        m_idx++;
                        m_out = (m_idx <= 8) ? m_rbyte[8 - m_idx] : 1'b1;
                    end
                end
            end
        end
    end

    // every-cycle comparison against the model
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            int exp;
            exp = !sel ? 1 : (m_busy > 0 ? 0 : int'(m_out));
            chk({cur_req, " per-cycle sdo"}, int'(sdo), exp);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic sel_set(input bit v);
        @(negedge clk);
        sel = v;
    endtask

    task automatic bit_out(input bit b);
        @(negedge clk);
        sdi = b;
        sclk = 1'b1;
        @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_hdr(input bit [1:0] op, input bit [6:0] ad);
        bit_out(1'b1);
        bit_out(op[1]);
        bit_out(op[0]);
        for (int i = 6; i >= 0; i--) bit_out(ad[i]);
    endtask

    task automatic read_tail(input int exp, input string req);
        int val = 0;
        #1;
        chk({req, " dummy bit"}, int'(sdo), 0);
        for (int i = 0; i < 8; i++) begin
            bit_out(1'b0);
            #1;
            val = (val << 1) | int'(sdo);
        end
        chk(req, val, exp);
    endtask

    task automatic read_chk(input bit [6:0] ad, input int exp, input string req);
        cur_req = req;
        sel_set(1'b1);
        send_hdr(2'b10, ad);
        read_tail(exp, req);
        sel_set(1'b0);
    endtask

    task automatic prog(input bit [1:0] op, input bit [6:0] ad, input bit has_data,
                        input bit [7:0] dat, input bit exp_busy, input string req);
        cur_req = req;
        sel_set(1'b1);
        send_hdr(op, ad);
        if (has_data) for (int i = 7; i >= 0; i--) bit_out(dat[i]);
        sel_set(1'b0);
        sel_set(1'b1);
        #1;
        chk({req, " busy flag"}, int'(sdo), exp_busy ? 0 : 1);
        sel_set(1'b0);
        repeat (TB_PROG + 4) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // ---------------- test sequence ----------------
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        cur_req = "R11";
        chk("R11 deselected output", int'(sdo), 1);
        sel_set(1'b1);
        #1;
        chk("R1 selected idle output", int'(sdo), 1);
        sel_set(1'b0);

        read_chk(7'h05, 8'hFF, "R1 reset content");

        // locked after reset: write refused
        prog(2'b01, 7'h03, 1'b1, 8'h5A, 1'b0, "R6 locked write");
        read_chk(7'h03, 8'hFF, "R6 locked write no effect");

        // unlock, then store
        prog(2'b00, 7'b1100000, 1'b0, 8'h00, 1'b0, "R6 unlock");
        prog(2'b01, 7'h03, 1'b1, 8'h5A, 1'b1, "R8 write busy");
        read_chk(7'h03, 8'h5A, "R4 write byte");

        // leading zeros before the start bit
        cur_req = "R2";
        sel_set(1'b1);
        bit_out(1'b0); bit_out(1'b0); bit_out(1'b0);
        send_hdr(2'b10, 7'h03);
        read_tail(8'h5A, "R2 zeros before start");
        sel_set(1'b0);

        // address extremes
        prog(2'b01, 7'h7F, 1'b1, 8'hC3, 1'b1, "R4 top address");
        prog(2'b01, 7'h00, 1'b1, 8'h81, 1'b1, "R4 bottom address");
        read_chk(7'h7F, 8'hC3, "R4 top readback");
        read_chk(7'h00, 8'h81, "R4 bottom readback");

        // single erase
        prog(2'b11, 7'h03, 1'b0, 8'h00, 1'b1, "R5 erase");
        read_chk(7'h03, 8'hFF, "R5 erased byte");
        read_chk(7'h7F, 8'hC3, "R5 neighbour kept");

        // aborted frame
        cur_req = "R10";
        sel_set(1'b1);
        send_hdr(2'b01, 7'h10);
        for (int i = 0; i < 5; i++) bit_out(1'b0);
        sel_set(1'b0);
        sel_set(1'b1);
        #1;
        chk("R10 abort starts no busy", int'(sdo), 1);
        sel_set(1'b0);
        read_chk(7'h10, 8'hFF, "R10 abort memory unchanged");

        // busy boundary: frame during busy ignored; rise in last busy cycle ignored
        cur_req = "R9";
        sel_set(1'b1);
        send_hdr(2'b01, 7'h11);
        for (int i = 7; i >= 0; i--) bit_out(i[0]);
        sel_set(1'b0);
        sel_set(1'b1);
        #1;
        chk("R8 busy under select", int'(sdo), 0);
        send_hdr(2'b01, 7'h12);
        for (int i = 0; i < 8; i++) bit_out(1'b0);
        while (m_busy != 1) @(negedge clk);
        sdi = 1'b1;
        sclk = 1'b1;
        @(negedge clk);
        sclk = 1'b0;
        #1;
        chk("R9 ready after last busy cycle", int'(sdo), 1);
        send_hdr(2'b10, 7'h11);
        read_tail(8'hAA, "R9 rise in last busy cycle ignored");
        sel_set(1'b0);
        read_chk(7'h12, 8'hFF, "R9 frame during busy ignored");

        // whole-array commands
        prog(2'b00, 7'b0100000, 1'b1, 8'h3C, 1'b1, "R7 fill all");
        read_chk(7'h00, 8'h3C, "R7 fill low");
        read_chk(7'h7F, 8'h3C, "R7 fill high");
        read_chk(7'h40, 8'h3C, "R7 fill mid");
        prog(2'b00, 7'b1000000, 1'b0, 8'h00, 1'b1, "R7 blank all");
        read_chk(7'h00, 8'hFF, "R7 blank low");
        read_chk(7'h55, 8'hFF, "R7 blank mid");

        // lock again, erase refused
        prog(2'b01, 7'h20, 1'b1, 8'h99, 1'b1, "R4 pre-lock write");
        prog(2'b00, 7'b0000000, 1'b0, 8'h00, 1'b0, "R6 lock");
        prog(2'b11, 7'h20, 1'b0, 8'h00, 1'b0, "R6 locked erase");
        prog(2'b00, 7'b1000000, 1'b0, 8'h00, 1'b0, "R6 locked blank all");
        read_chk(7'h20, 8'h99, "R6 locked erase no effect");

        // extra clocks after a read
        cur_req = "R3";
        sel_set(1'b1);
        send_hdr(2'b10, 7'h20);
        read_tail(8'h99, "R3 read bits");
        bit_out(1'b0);
        #1;
        chk("R3 output released after eight bits", int'(sdo), 1);
        bit_out(1'b0);
        #1;
        chk("R3 output stays released", int'(sdo), 1);
        sel_set(1'b0);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule